// File: doc/BRIEF.md
# Address-Match Breakpoint and Run-Control Unit

This unit sits beside a small 8-bit microcontroller core and decides when the core must stop. It looks at the program counter each time the core retires an instruction. It holds three things: a short table of breakpoint addresses, one stop address, and an instruction budget. Commands on a single command port edit all three. The table accepts set, clear, clear-all and toggle commands. When an entry is removed, the later entries move down one slot each, so the table keeps the order in which addresses were added. A select port reads any slot back.

A halt is raised in two cases. The first is a retired instruction whose new PC matches a live breakpoint or the stop address, that uses up the budget, or that coincides with an external break request. The second is a fetch request aimed past the end of program memory. The halt and a cause code stay latched until a resume command arrives. While the unit is halted, further retire and fetch strobes are ignored.

Top module: `bkrc_top`

## Requirements
- R1: After reset the outputs hold these values: `halt` 0, cause 0, `bp_hit` 0, `cmd_err` 0, table count 0, and budget all ones. The stop address resets to 0.
- R2: The command codes are: 0 no-op, 1 set, 2 clear, 3 clear-all, 4 toggle, 5 load stop address, 6 load budget, 7 resume. A set command (code 1) appends its address in the next free slot. This happens only if the address is not already in the table and the table holds fewer than NUM_BP entries. Otherwise the table is left unchanged and no error is flagged.
- R3: An address is out of range when it is greater than PMEM_LAST. A set, clear or toggle command with an out-of-range address leaves the table unchanged and pulses `cmd_err` high for one cycle.
- R4: A clear command (code 2) for an in-range address that is not in the table leaves the table unchanged and pulses `cmd_err`.
- R5: A clear command for a present address removes it. Every later entry moves down one slot, so the order of insertion is kept.
- R6: Clear-all (code 3) empties the table, and afterwards no address raises a breakpoint halt.
- R7: Toggle (code 4) removes the address if it is present. If it is absent, toggle behaves like a set command.
- R8: A retire whose new PC matches a live entry halts with cause 1 one cycle later and sets `bp_hit`. No other cause sets `bp_hit`.
- R9: The stop-address match halts with cause 2 only while the stop register is nonzero. A zero stop address never halts.
- R10: A budget value of all ones disables counting. Any other value drops by one on each retire, and the unit halts with cause 3 on the retire that leaves it at zero. A budget of zero halts on every retire.
- R11: The external break input, when sampled high together with a retire, halts with cause 4.
- R12: A fetch request whose PC is above PMEM_LAST halts with cause 5. A fetch at PMEM_LAST itself does not.
- R13: When several causes occur on the same edge, the cause code is chosen in this order: 5, then 1, 2, 3, 4. The halt, the cause and `bp_hit` hold until a resume command (code 7) clears all three. Retires and fetches arriving while halted have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | ADDR_W | Command address or load value |
| retire | input | 1 | Instruction retired strobe |
| new_pc | input | ADDR_W | PC after the retired instruction |
| ext_break | input | 1 | External break request, sampled with retire |
| fetch_req | input | 1 | Fetch about to start |
| fetch_pc | input | ADDR_W | Address of that fetch |
| ent_sel | input | IW | Table slot to read back |
| halt | output | 1 | Core must stop |
| halt_cause | output | 3 | Latched cause code |
| bp_hit | output | 1 | Halt came from a breakpoint |
| cmd_err | output | 1 | One-cycle pulse for a rejected command |
| bp_count | output | CW | Live table entries |
| budget_left | output | ADDR_W | Remaining instruction budget |
| ent_addr | output | ADDR_W | Address held in slot `ent_sel` |
| ent_valid | output | 1 | Slot `ent_sel` is live |

## Verification
The hardest state to reach is a full table from which one middle entry is then removed. Reaching it needs a chain of commands: fills, a rejected duplicate, a rejected overflow and a mid-table clear. Only after that chain can the slot readback confirm that order was kept. The stimulus builds the table step by step and reads every slot after each edit. It then places the stop address on a live breakpoint so that two causes fire on one edge, and it drives the budget all the way down to zero, where every later retire halts.

// File: rtl/bkrc_pkg.sv
package bkrc_pkg;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_SET    = 3'd1,
    OP_CLR    = 3'd2,
    OP_CLRALL = 3'd3,
    OP_TOGGLE = 3'd4,
    OP_STOP   = 3'd5,
    OP_BUDGET = 3'd6,
    OP_RESUME = 3'd7
  } bkrc_op_e;

  typedef enum logic [2:0] {
    HC_NONE  = 3'd0,
    HC_BKPT  = 3'd1,
    HC_STOP  = 3'd2,
    HC_COUNT = 3'd3,
    HC_EXT   = 3'd4,
    HC_FAULT = 3'd5
  } bkrc_cause_e;

  // Address lies inside program memory.
  function automatic logic addr_ok(input logic [31:0] a, input logic [31:0] last);
    return a <= last;
  endfunction

  // Fixed priority among simultaneous halt events.
  function automatic logic [2:0] pick_cause(input logic f, input logic b,
                                            input logic s, input logic c,
                                            input logic e);
    if (f) return HC_FAULT;
    if (b) return HC_BKPT;
    if (s) return HC_STOP;
    if (c) return HC_COUNT;
    if (e) return HC_EXT;
    return HC_NONE;
  endfunction

endpackage

// File: rtl/bkrc_table.sv
module bkrc_table #(
  parameter int ADDR_W    = 16,
  parameter int NUM_BP    = 4,
  parameter int PMEM_LAST = 16'h0FFF,
  localparam int CW = $clog2(NUM_BP + 1),
  localparam int IW = (NUM_BP > 1) ? $clog2(NUM_BP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              probe_en,
  input  logic [ADDR_W-1:0] probe_pc,
  input  logic [IW-1:0]     ent_sel,
  output logic [ADDR_W-1:0] ent_addr,
  output logic              ent_valid,
  output logic [CW-1:0]     count,
  output logic              hit,
  output logic              cmd_err
);
  import bkrc_pkg::*;

  logic [ADDR_W-1:0] ent_q     [NUM_BP];
  logic [ADDR_W-1:0] shift_src [NUM_BP];
  logic [CW-1:0]     cnt_q;
  logic [NUM_BP-1:0] live, cmd_eq, pc_eq;
  logic [IW-1:0]     del_idx;
  logic              present, full, in_rng;
  logic              do_set, do_del, do_clrall, err_now;

  for (genvar gi = 0; gi < NUM_BP; gi++) begin : g_slot
    assign live[gi]   = CW'(gi) < cnt_q;
    assign cmd_eq[gi] = live[gi] && (ent_q[gi] == cmd_addr);
    assign pc_eq[gi]  = live[gi] && (ent_q[gi] == probe_pc);
    if (gi < NUM_BP - 1) begin : g_mid
      assign shift_src[gi] = ent_q[gi+1];
    end else begin : g_last
      assign shift_src[gi] = '0;
    end
  end

  assign present = |cmd_eq;
  assign full    = (cnt_q == CW'(NUM_BP));
  assign in_rng  = addr_ok(32'(cmd_addr), 32'(PMEM_LAST));
  assign hit     = probe_en && (|pc_eq);

  always_comb begin
    del_idx = '0;
    for (int i = NUM_BP - 1; i >= 0; i--)
      if (cmd_eq[i]) del_idx = IW'(i);
  end

  always_comb begin
    do_set = 1'b0; do_del = 1'b0; do_clrall = 1'b0; err_now = 1'b0;
    if (cmd_valid) begin
      case (cmd_op)
        OP_SET: begin
          if (!in_rng) err_now = 1'b1;
          else         do_set  = !present && !full;
        end
        OP_CLR: begin
          if (!in_rng || !present) err_now = 1'b1;
          else                     do_del  = 1'b1;
        end
        OP_TOGGLE: begin
          if (!in_rng)      err_now = 1'b1;
          else if (present) do_del  = 1'b1;
          else              do_set  = !full;
        end
        OP_CLRALL: do_clrall = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      cmd_err <= 1'b0;
      for (int i = 0; i < NUM_BP; i++) ent_q[i] <= '0;
    end else begin
      cmd_err <= err_now;
      if (do_clrall) begin
        cnt_q <= '0;
      end else if (do_set) begin
        for (int i = 0; i < NUM_BP; i++)
          if (CW'(i) == cnt_q) ent_q[i] <= cmd_addr;
        cnt_q <= cnt_q + 1'b1;
      end else if (do_del) begin
        for (int i = 0; i < NUM_BP; i++)
          if (IW'(i) >= del_idx) ent_q[i] <= shift_src[i];
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign count     = cnt_q;
  assign ent_addr  = ent_q[ent_sel];
  assign ent_valid = 32'(ent_sel) < 32'(cnt_q);

endmodule

// File: rtl/bkrc_budget.sv
module bkrc_budget #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic [W-1:0] left,
  output logic         zero_hit
);
  logic [W-1:0] left_q, nxt;
  logic         off;

  // Saturating decrement toward zero.
  function automatic logic [W-1:0] step_down(input logic [W-1:0] b);
    return (b == '0) ? '0 : b - 1'b1;
  endfunction

  assign off      = &left_q;
  assign nxt      = step_down(left_q);
  assign zero_hit = tick && !off && (nxt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             left_q <= '1;
    else if (load)          left_q <= load_val;
    else if (tick && !off)  left_q <= nxt;
  end

  assign left = left_q;

endmodule

// File: rtl/bkrc_halt.sv
module bkrc_halt (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       resume,
  input  logic       fault_ev,
  input  logic       bp_ev,
  input  logic       stop_ev,
  input  logic       cnt_ev,
  input  logic       ext_ev,
  output logic       halt,
  output logic [2:0] cause,
  output logic       bp_hit
);
  import bkrc_pkg::*;

  logic any_ev;
  assign any_ev = fault_ev | bp_ev | stop_ev | cnt_ev | ext_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt <= 1'b0; cause <= HC_NONE; bp_hit <= 1'b0;
    end else if (resume) begin
      halt <= 1'b0; cause <= HC_NONE; bp_hit <= 1'b0;
    end else if (!halt && any_ev) begin
      halt   <= 1'b1;
      cause  <= pick_cause(fault_ev, bp_ev, stop_ev, cnt_ev, ext_ev);
      bp_hit <= bp_ev;
    end
  end

endmodule

// File: rtl/bkrc_top.sv
module bkrc_top #(
  parameter int ADDR_W    = 16,
  parameter int NUM_BP    = 4,
  parameter int PMEM_LAST = 16'h0FFF,
  localparam int CW = $clog2(NUM_BP + 1),
  localparam int IW = (NUM_BP > 1) ? $clog2(NUM_BP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              retire,
  input  logic [ADDR_W-1:0] new_pc,
  input  logic              ext_break,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic [IW-1:0]     ent_sel,
  output logic              halt,
  output logic [2:0]        halt_cause,
  output logic              bp_hit,
  output logic              cmd_err,
  output logic [CW-1:0]     bp_count,
  output logic [ADDR_W-1:0] budget_left,
  output logic [ADDR_W-1:0] ent_addr,
  output logic              ent_valid
);
  import bkrc_pkg::*;

  // Named internal events, also observed by the checker.
  logic              retire_live, resume_cmd;
  logic              tbl_hit, stop_hit, cnt_zero, ext_hit, fetch_fault;
  logic [ADDR_W-1:0] stop_q;

  assign resume_cmd  = cmd_valid && (cmd_op == OP_RESUME);
  assign retire_live = retire && !halt;
  assign stop_hit    = retire_live && (stop_q != '0) && (new_pc == stop_q);
  assign ext_hit     = retire_live && ext_break;
  assign fetch_fault = fetch_req && !halt && !addr_ok(32'(fetch_pc), 32'(PMEM_LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stop_q <= '0;
    else if (cmd_valid && (cmd_op == OP_STOP)) stop_q <= cmd_addr;
  end

  bkrc_table #(.ADDR_W(ADDR_W), .NUM_BP(NUM_BP), .PMEM_LAST(PMEM_LAST)) u_table (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .probe_en(retire_live), .probe_pc(new_pc),
    .ent_sel(ent_sel), .ent_addr(ent_addr), .ent_valid(ent_valid),
    .count(bp_count), .hit(tbl_hit), .cmd_err(cmd_err)
  );

  bkrc_budget #(.W(ADDR_W)) u_budget (
    .clk(clk), .rst_n(rst_n),
    .load(cmd_valid && (cmd_op == OP_BUDGET)), .load_val(cmd_addr),
    .tick(retire_live), .left(budget_left), .zero_hit(cnt_zero)
  );

  bkrc_halt u_halt (
    .clk(clk), .rst_n(rst_n), .resume(resume_cmd),
    .fault_ev(fetch_fault), .bp_ev(tbl_hit), .stop_ev(stop_hit),
    .cnt_ev(cnt_zero), .ext_ev(ext_hit),
    .halt(halt), .cause(halt_cause), .bp_hit(bp_hit)
  );

endmodule

// File: rtl/bkrc_checker.sv
module bkrc_checker #(
  parameter int NUM_BP = 4,
  localparam int CW = $clog2(NUM_BP + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [2:0]    cmd_op,
  input logic          halt,
  input logic [2:0]    halt_cause,
  input logic          bp_hit,
  input logic [CW-1:0] bp_count,
  input logic          tbl_hit,
  input logic          stop_hit,
  input logic          cnt_zero,
  input logic          ext_hit,
  input logic          fetch_fault
);
  logic resume;
  assign resume = cmd_valid && (cmd_op == 3'd7);

  p_cause_halt_r13: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> (halt_cause != 3'd0));
  p_idle_clean_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !halt |-> (halt_cause == 3'd0) && !bp_hit);
  p_latch_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !resume) |=> halt && $stable(halt_cause) && $stable(bp_hit));
  p_count_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bp_count <= CW'(NUM_BP));
  p_clrall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd3) |=> (bp_count == '0));
  p_bp_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_hit && !fetch_fault && !resume) |=> halt && (halt_cause == 3'd1) && bp_hit);
  p_bp_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bp_hit) |-> (halt_cause == 3'd1));
  p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_hit && !tbl_hit && !fetch_fault && !resume) |=> (halt_cause == 3'd2));
  p_ext_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_hit && !tbl_hit && !stop_hit && !cnt_zero && !fetch_fault && !resume)
      |=> (halt_cause == 3'd4));
  p_fault_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_fault && !resume) |=> halt && (halt_cause == 3'd5));

endmodule

bind bkrc_top bkrc_checker #(.NUM_BP(NUM_BP)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .halt(halt), .halt_cause(halt_cause), .bp_hit(bp_hit), .bp_count(bp_count),
  .tbl_hit(tbl_hit), .stop_hit(stop_hit), .cnt_zero(cnt_zero),
  .ext_hit(ext_hit), .fetch_fault(fetch_fault)
);

// File: tb/bkrc_top_tb.sv
module bkrc_top_tb;
  localparam int          NB   = 4;
  localparam logic [15:0] LAST = 16'h0FFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [15:0] cmd_addr = '0;
  logic        retire = 1'b0;
  logic [15:0] new_pc = '0;
  logic        ext_break = 1'b0;
  logic        fetch_req = 1'b0;
  logic [15:0] fetch_pc = '0;
  logic [1:0]  ent_sel = '0;
  logic        halt, bp_hit, cmd_err, ent_valid;
  logic [2:0]  halt_cause;
  logic [2:0]  bp_count;
  logic [15:0] budget_left, ent_addr;

  bkrc_top u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .retire(retire), .new_pc(new_pc),
    .ext_break(ext_break), .fetch_req(fetch_req), .fetch_pc(fetch_pc),
    .ent_sel(ent_sel), .halt(halt), .halt_cause(halt_cause), .bp_hit(bp_hit),
    .cmd_err(cmd_err), .bp_count(bp_count), .budget_left(budget_left),
    .ent_addr(ent_addr), .ent_valid(ent_valid)
  );

  always #5 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Reference state, written from the requirements.
  logic [15:0] mq[$];
  logic [15:0] m_stop = '0;
  logic [15:0] m_bud  = 16'hFFFF;
  logic        m_halt = 1'b0;
  logic [2:0]  m_cause = 3'd0;
  logic        m_bph = 1'b0;

  typedef struct {
    int          due;
    logic        h;
    logic [2:0]  c;
    logic        b;
    int          n;
    logic        e;
    logic [15:0] bud;
    string       tag;
  } exp_t;
  exp_t sq[$];
  exp_t cur;

  function automatic int mfind(input logic [15:0] a);
    foreach (mq[i]) if (mq[i] == a) return i;
    return -1;
  endfunction

  // Monitor: compares each expected item in the cycle it falls due.
  always @(negedge clk) begin
    while (sq.size() > 0 && sq[0].due <= cyc) begin
      cur = sq.pop_front();
      n_tests++;
      if (halt !== cur.h || halt_cause !== cur.c || bp_hit !== cur.b ||
          int'(bp_count) != cur.n || cmd_err !== cur.e || budget_left !== cur.bud) begin
        n_fail++;
        $display("FAIL %s: actual halt=%0b cause=%0d hit=%0b cnt=%0d err=%0b bud=%h expected halt=%0b cause=%0d hit=%0b cnt=%0d err=%0b bud=%h",
                 cur.tag, halt, halt_cause, bp_hit, bp_count, cmd_err, budget_left,
                 cur.h, cur.c, cur.b, cur.n, cur.e, cur.bud);
      end
    end
  end

  // Driver: applies one cycle of stimulus and queues the expected result.
  task automatic step(input logic cv, input logic [2:0] op, input logic [15:0] a,
                      input logic ret, input logic [15:0] npc, input logic ext,
                      input logic fr, input logic [15:0] fpc, input string tag);
    exp_t x;
    int k;
    logic e, res, live, bpm, sm, cz, flt, inr;
    logic [2:0] c;
    cmd_valid = cv; cmd_op = op; cmd_addr = a; retire = ret; new_pc = npc;
    ext_break = ext; fetch_req = fr; fetch_pc = fpc;
    e = 1'b0;
    res  = cv && (op == 3'd7);
    live = ret && !m_halt;
    bpm  = live && (mfind(npc) >= 0);
    sm   = live && (m_stop != 0) && (npc == m_stop);
    cz   = 1'b0;
    if (live && m_bud != 16'hFFFF) begin
      if (m_bud != 0) m_bud = m_bud - 16'd1;
      cz = (m_bud == 0);
    end
    flt = fr && (fpc > LAST);
    if (res) begin
      m_halt = 1'b0; m_cause = 3'd0; m_bph = 1'b0;
    end else if (!m_halt) begin
      c = flt ? 3'd5 : bpm ? 3'd1 : sm ? 3'd2 : cz ? 3'd3 : (live && ext) ? 3'd4 : 3'd0;
      if (c != 0) begin m_halt = 1'b1; m_cause = c; m_bph = bpm; end
    end
    if (cv) begin
      k = mfind(a);
      inr = (a <= LAST);
      case (op)
        3'd1: if (!inr) e = 1; else if (k < 0 && mq.size() < NB) mq.push_back(a);
        3'd2: if (!inr || k < 0) e = 1; else mq.delete(k);
        3'd3: mq.delete();
        3'd4: if (!inr) e = 1; else if (k >= 0) mq.delete(k);
              else if (mq.size() < NB) mq.push_back(a);
        3'd5: m_stop = a;
        3'd6: m_bud = a;
        default: ;
      endcase
    end
    x.due = cyc + 1; x.h = m_halt; x.c = m_cause; x.b = m_bph; x.n = mq.size();
    x.e = e; x.bud = m_bud; x.tag = tag;
    sq.push_back(x);
    @(negedge clk);
    cmd_valid = 0; retire = 0; ext_break = 0; fetch_req = 0;
  endtask

  task automatic cmd(input logic [2:0] op, input logic [15:0] a, input string tag);
    step(1'b1, op, a, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0, tag);
  endtask
  task automatic ret(input logic [15:0] pc, input logic ext, input string tag);
    step(1'b0, 3'd0, 16'h0, 1'b1, pc, ext, 1'b0, 16'h0, tag);
  endtask
  task automatic fetch(input logic [15:0] pc, input string tag);
    step(1'b0, 3'd0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b1, pc, tag);
  endtask

  // Reads every slot back and compares with the reference order.
  task automatic chk_slots(input string tag);
    for (int i = 0; i < NB; i++) begin
      ent_sel = 2'(i);
      #1;
      n_tests++;
      if (i < mq.size()) begin
        if (!ent_valid || ent_addr !== mq[i]) begin
          n_fail++;
          $display("FAIL %s slot %0d: actual v=%0b a=%h expected v=1 a=%h",
                   tag, i, ent_valid, ent_addr, mq[i]);
        end
      end else if (ent_valid) begin
        n_fail++;
        $display("FAIL %s slot %0d: actual v=1 expected v=0", tag, i);
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual run still busy expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    n_tests++;
    if (halt !== 0 || halt_cause !== 0 || bp_hit !== 0 || cmd_err !== 0 ||
        bp_count !== 0 || budget_left !== 16'hFFFF || ent_valid !== 0) begin
      n_fail++;
      $display("FAIL R1: actual halt=%0b cause=%0d cnt=%0d bud=%h expected 0 0 0 ffff",
               halt, halt_cause, bp_count, budget_left);
    end
    // R2 appends in order, duplicates and overflow ignored
    cmd(3'd1, 16'h0100, "R2 set 100");
    cmd(3'd1, 16'h0200, "R2 set 200");
    cmd(3'd1, 16'h0300, "R2 set 300");
    chk_slots("R2 order");
    cmd(3'd1, 16'h0200, "R2 duplicate");
    // R3 out of range
    cmd(3'd1, 16'h1000, "R3 set out of range");
    cmd(3'd2, 16'h2000, "R3 clear out of range");
    cmd(3'd4, 16'hF000, "R3 toggle out of range");
    chk_slots("R3 unchanged");
    cmd(3'd1, 16'h0FFF, "R2 set at limit");
    cmd(3'd1, 16'h0500, "R2 full ignored");
    chk_slots("R2 full");
    // R5 removal compacts
    cmd(3'd2, 16'h0200, "R5 clear middle");
    chk_slots("R5 compact");
    // R4 clear absent
    cmd(3'd2, 16'h0777, "R4 clear absent");
    chk_slots("R4 unchanged");
    // R7 toggle both ways
    cmd(3'd4, 16'h0300, "R7 toggle present");
    cmd(3'd4, 16'h0600, "R7 toggle absent");
    chk_slots("R7 order");
    // R8 breakpoint halt
    ret(16'h0050, 1'b0, "R8 no match");
    ret(16'h0FFF, 1'b0, "R8 match");
    ret(16'h0100, 1'b1, "R13 ignored while halted");
    cmd(3'd7, 16'h0, "R13 resume");
    // R9 stop point
    ret(16'h0123, 1'b0, "R9 zero stop disabled");
    cmd(3'd5, 16'h0123, "R9 load stop");
    ret(16'h0123, 1'b0, "R9 stop hit");
    cmd(3'd7, 16'h0, "R13 resume");
    // R13 priority breakpoint over stop
    cmd(3'd5, 16'h0100, "R13 stop on breakpoint");
    ret(16'h0100, 1'b0, "R13 priority bp");
    cmd(3'd7, 16'h0, "R13 resume");
    cmd(3'd5, 16'h0, "R9 clear stop");
    ret(16'h0100 + 16'h0001, 1'b0, "R9 no halt");
    // R10 budget
    cmd(3'd6, 16'd3, "R10 load 3");
    ret(16'h0050, 1'b0, "R10 dec 2");
    ret(16'h0051, 1'b0, "R10 dec 1");
    ret(16'h0052, 1'b0, "R10 reaches zero");
    cmd(3'd7, 16'h0, "R13 resume");
    ret(16'h0053, 1'b0, "R10 zero halts again");
    cmd(3'd7, 16'h0, "R13 resume");
    cmd(3'd6, 16'hFFFF, "R10 disable");
    for (int i = 0; i < 5; i++) ret(16'h0060 + 16'(i), 1'b0, "R10 disabled");
    // R11 external break
    ret(16'h0070, 1'b1, "R11 ext");
    cmd(3'd7, 16'h0, "R13 resume");
    // R12 fetch limit
    fetch(16'h0FFF, "R12 at limit");
    fetch(16'h1000, "R12 past limit");
    fetch(16'h2000, "R13 fetch ignored while halted");
    cmd(3'd7, 16'h0, "R13 resume");
    // R6 clear all
    cmd(3'd3, 16'h0, "R6 clear all");
    ret(16'h0100, 1'b0, "R6 no breakpoint");
    chk_slots("R6 empty");
    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule